// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-programmed master for the two-wire Ethernet station management bus. Software loads a small set of word-aligned registers through a simple single-cycle register port. A write to the command register with its start bit set launches one complete serial frame on MDC/MDIO. That frame can use Clause 22 or Clause 45 framing. It can be a Clause 45 address phase, a data write, a read, or a read with post-increment.

The engine generates MDC from the system clock, drives or releases the MDIO line through a separate enable, and shifts received read data into a read-data register. It raises a failure flag when no device answers a read. Multi-frame sequences, such as an address phase followed by a read, are issued by the host one frame at a time. The host polls the self-clearing start bit between frames.

The register port carries no stream. Each access completes in the cycle it is presented, so the port has no valid/ready handshake and no back-pressure. The only flow control is the start bit, which the host must see clear before it issues the next command.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads zero, MDC is low and the MDIO enable is low (line released).
- R2: A command write (byte offset 0x0) with bit 14 set, while idle, starts a frame of exactly 64 MDC periods. Bit 14 reads 1 from the next cycle until the frame ends, then reads 0. The line is driven from the first preamble bit.
- R3: The frame is sent MSB first on the MDC falling edge: 32 ones, a 2-bit start field, opcode = command bits 11:10, port address = bits 9:5, register/device address = bits 4:0, turnaround, then 16 data bits. For writes the turnaround is 10 and the data is the low 16 bits of the write-data register (offset 0x8).
- R4: Command bits 13:12 = 0 selects Clause 45, with start field 00. Any other value selects Clause 22, with start field 01. A Clause 45 frame with opcode 00 takes its data from the low 16 bits of the address register (offset 0x4).
- R5: Read frames are Clause 22 opcode 10, and Clause 45 opcodes 11 and 10. In a read frame the master releases MDIO from the first turnaround bit (frame bit 46) to the end. It samples the line on the MDC rising edge, and the 16 data bits appear in the low bits of the read-data register (offset 0xC) when the frame completes.
- R6: Status bit 0 (offset 0x10) is set after a read if the line was not low during the second turnaround bit (frame bit 47). It is cleared when the next frame is launched.
- R7: MDC has a period of CLK_DIV system clocks and a 50 % duty cycle while a frame runs. It stays low when idle.
- R8: A command write while a frame is in progress is ignored. The stored fields are kept and no extra frame is sent.
- R9: A command write with bit 14 clear stores the fields (readable in bits 13:0) and launches nothing.
- R10: A Clause 45 read with post-increment (opcode 10) uses the read behaviour of R5 and captures data the same way as opcode 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on MDIO |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | Resolved MDIO line value |

## Verification
A wrong bit index or a shift on the wrong MDC edge shows up in the captured frame within one MDC period of the fault: a header field arrives displaced, or a write turnaround appears as 11. A stuck or early busy state shows at the ports as a frame that is not exactly 64 MDC rising edges long, or as a start bit that clears before the last falling edge. A wrong release point or sampling point is exposed by reads against an answering and a silent device. The read-data and status registers then disagree with the bench's model as soon as the frame ends.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam int WORD_CMD  = 0;
  localparam int WORD_ADR  = 1;
  localparam int WORD_WDAT = 2;
  localparam int WORD_RDAT = 3;
  localparam int WORD_STAT = 4;

  localparam int START_BIT = 14;

  typedef struct packed {
    logic [1:0] sof;
    logic [1:0] op;
    logic [4:0] pa;
    logic [4:0] ra;
  } cmd_t;

  function automatic logic is_c45(cmd_t c);
    return c.sof == 2'b00;
  endfunction

  function automatic logic is_read(cmd_t c);
    if (is_c45(c)) return c.op[1];
    else           return c.op == 2'b10;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign rise_stb = run && (cnt_q == CW'(HALF - 1));
  assign fall_stb = run && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= fall_stb ? '0 : cnt_q + 1'b1;
      if (rise_stb)      mdc <= 1'b1;
      else if (fall_stb) mdc <= 1'b0;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb})); // R7
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc); // R7
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  cmd_t        cmd,
  input  logic [15:0] tx_data,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        busy,
  output logic        finish,
  output logic        rd_mode,
  output logic [15:0] rd_data,
  output logic        rd_fail,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q;
  logic                  rd_mode_q;
  logic [15:0]           shin_q;
  logic                  rd_fail_q;
  logic [1:0]            st_field;
  logic [1:0]            ta_field;
  logic                  released;

  assign st_field = is_c45(cmd) ? 2'b00 : 2'b01;
  assign ta_field = is_read(cmd) ? 2'b11 : 2'b10;
  assign finish   = busy_q && fall_stb && (idx_q == IDX_W'(FRAME_BITS - 1));
  assign released = rd_mode_q && (idx_q >= IDX_W'(TA_FIRST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q   <= '0;
      idx_q     <= '0;
      busy_q    <= 1'b0;
      rd_mode_q <= 1'b0;
      shin_q    <= '0;
      rd_fail_q <= 1'b0;
    end else if (launch && !busy_q) begin
      frame_q   <= {32'hFFFF_FFFF, st_field, cmd.op, cmd.pa, cmd.ra, ta_field, tx_data};
      idx_q     <= '0;
      busy_q    <= 1'b1;
      rd_mode_q <= is_read(cmd);
      rd_fail_q <= 1'b0;
    end else if (busy_q) begin
      if (rise_stb && rd_mode_q) begin
        if (idx_q == IDX_W'(TA_SECOND)) rd_fail_q <= mdio_i;
        if (idx_q >= IDX_W'(DATA_FIRST)) shin_q <= {shin_q[14:0], mdio_i};
      end
      if (fall_stb) begin
        if (finish) busy_q <= 1'b0;
        else begin
          idx_q   <= idx_q + 1'b1;
          frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign busy    = busy_q;
  assign rd_mode = rd_mode_q;
  assign rd_data = shin_q;
  assign rd_fail = rd_fail_q;
  assign mdio_o  = busy_q ? frame_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy_q && !released;

  AST_DRIVE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (mdio_oe && mdio_o)); // R2
  AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_stb) |=> $stable(mdio_o)); // R3
  AST_FAIL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy_q) |=> !rd_fail_q); // R6
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          busy,
  input  logic          finish,
  input  logic          rd_mode,
  input  logic [15:0]   rd_data,
  input  logic          rd_fail,
  output logic          launch,
  output cmd_t          launch_cmd,
  output logic [15:0]   tx_data
);
  localparam int WW = AW - 2;

  logic [WW-1:0] word;
  cmd_t          cmd_q;
  logic [15:0]   adr_q;
  logic [15:0]   wdat_q;
  logic [15:0]   rdat_q;
  logic          stat_q;
  logic          cmd_wr;

  assign word       = reg_addr[AW-1:2];
  assign cmd_wr     = reg_we && (int'(word) == WORD_CMD);
  assign launch     = cmd_wr && reg_wdata[START_BIT] && !busy;
  assign launch_cmd = cmd_t'(reg_wdata[13:0]);
  assign tx_data    = (is_c45(launch_cmd) && launch_cmd.op == 2'b00) ? adr_q : wdat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      adr_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      stat_q <= 1'b0;
    end else begin
      if (cmd_wr && !busy) cmd_q <= launch_cmd;
      if (reg_we && int'(word) == WORD_ADR)  adr_q  <= reg_wdata[15:0];
      if (reg_we && int'(word) == WORD_WDAT) wdat_q <= reg_wdata[15:0];
      if (launch) stat_q <= 1'b0;
      else if (finish && rd_mode) begin
        rdat_q <= rd_data;
        stat_q <= rd_fail;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (int'(word))
      WORD_CMD:  reg_rdata = {17'd0, busy, cmd_q};
      WORD_ADR:  reg_rdata = {16'd0, adr_q};
      WORD_WDAT: reg_rdata = {16'd0, wdat_q};
      WORD_RDAT: reg_rdata = {16'd0, rdat_q};
      WORD_STAT: reg_rdata = {31'd0, stat_q};
      default:   reg_rdata = '0;
    endcase
  end

  AST_CMD_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q)); // R8
  AST_RDAT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(rdat_q)); // R5
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int AW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  logic        busy, finish, rd_mode, rd_fail, launch;
  logic        rise_stb, fall_stb;
  logic [15:0] rd_data, tx_data;
  cmd_t        launch_cmd;

  mdio_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .finish(finish),
    .rd_mode(rd_mode), .rd_data(rd_data), .rd_fail(rd_fail), .launch(launch),
    .launch_cmd(launch_cmd), .tx_data(tx_data)
  );

  mdio_clkgen #(.DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(launch_cmd), .tx_data(tx_data),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i), .busy(busy),
    .finish(finish), .rd_mode(rd_mode), .rd_data(rd_data), .rd_fail(rd_fail),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int AW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic        phy_rd = 1'b0;
  logic        phy_en = 1'b0;
  logic [15:0] phy_data = '0;
  logic        tb_clr = 1'b0;
  int          bitcnt = 0;
  logic [63:0] cap = '0;
  logic        mdc_d = 1'b0;
  int          last_rise = 0;
  int          period = 0;
  logic        phy_drive, phy_bit;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.CLK_DIV(DIV), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign phy_drive = phy_en && phy_rd && bitcnt >= 47 && bitcnt < 64;
  assign phy_bit   = (bitcnt == 47) ? 1'b0 : phy_data[(63 - bitcnt) & 15];
  assign mdio_i    = mdio_oe ? mdio_o : (phy_drive ? phy_bit : 1'b1);

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    mdc_d <= mdc;
    if (tb_clr) bitcnt <= 0;
    else if (mdc && !mdc_d) begin
      cap       <= {cap[62:0], mdio_i};
      bitcnt    <= bitcnt + 1;
      period    <= cyc - last_rise;
      last_rise <= cyc;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails = fails + 1;
    $display("FAIL watchdog: run did not end");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 64 * DIV * 2; i++) begin
      @(negedge clk);
      rd(0, v);
      if (!v[14]) break;
    end
  endtask

  function automatic logic [31:0] cmdw(logic s, logic [1:0] sof, logic [1:0] op,
                                       logic [4:0] pa, logic [4:0] ra);
    return {17'd0, s, sof, op, pa, ra};
  endfunction

  task automatic clr_cnt();
    @(negedge clk); tb_clr = 1'b1;
    @(negedge clk); tb_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    for (int a = 0; a <= 16; a += 4) begin
      rd(a, v);
      check("R1 reg reset", 64'(v), 64'd0);
    end
    check("R1 mdc low", 64'(mdc), 64'd0);
    check("R1 oe low", 64'(mdio_oe), 64'd0);
  endtask

  task automatic t_write(logic [1:0] sof, logic [1:0] op, logic [4:0] pa,
                         logic [4:0] ra, logic [15:0] d, string req);
    logic [31:0] v;
    logic [1:0] st;
    st = (sof == 2'b00) ? 2'b00 : 2'b01;
    phy_rd = 1'b0;
    clr_cnt();
    if (sof == 2'b00 && op == 2'b00) wr(4, {16'd0, d});
    else wr(8, {16'd0, d});
    wr(0, cmdw(1'b1, sof, op, pa, ra));
    rd(0, v);
    check("R2 start bit reads busy", 64'(v[14]), 64'd1);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R2 64 mdc periods", 64'(bitcnt), 64'd64);
    check(req, cap, {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d});
  endtask

  task automatic t_read(logic [1:0] sof, logic [1:0] op, logic [4:0] pa,
                        logic [4:0] ra, logic present, logic [15:0] d, string req);
    logic [31:0] v;
    logic [1:0] st;
    logic [63:0] e;
    st = (sof == 2'b00) ? 2'b00 : 2'b01;
    e = {32'hFFFF_FFFF, st, op, pa, ra, 2'b11, 16'h0};
    phy_rd = 1'b1; phy_en = present; phy_data = d;
    clr_cnt();
    wr(0, cmdw(1'b1, sof, op, pa, ra));
    wait_idle();
    repeat (2) @(negedge clk);
    check({req, " header"}, 64'(cap[63:18]), 64'(e[63:18]));
    check("R5 released in first turnaround", 64'(cap[17]), 64'd1);
    rd(12, v);
    check({req, " read data"}, 64'(v), present ? 64'(d) : 64'hFFFF);
    rd(16, v);
    check("R6 fail status", 64'(v), present ? 64'd0 : 64'd1);
    phy_rd = 1'b0;
  endtask

  task automatic t_period();
    logic [31:0] v;
    phy_rd = 1'b0;
    clr_cnt();
    wr(0, cmdw(1'b1, 2'b01, 2'b01, 5'd1, 5'd2));
    repeat (DIV * 5) @(negedge clk);
    check("R7 mdc period", 64'(period), 64'(DIV));
    wait_idle();
    repeat (DIV * 2) @(negedge clk);
    check("R7 mdc low when idle", 64'(mdc), 64'd0);
    rd(0, v);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    phy_rd = 1'b0;
    clr_cnt();
    wr(0, cmdw(1'b1, 2'b01, 2'b01, 5'd3, 5'd4));
    repeat (DIV * 4) @(negedge clk);
    wr(0, cmdw(1'b1, 2'b00, 2'b11, 5'd30, 5'd29));
    wait_idle();
    repeat (DIV * 4) @(negedge clk);
    check("R8 no second frame", 64'(bitcnt), 64'd64);
    rd(0, v);
    check("R8 fields kept", 64'(v[13:0]), 64'(cmdw(1'b0, 2'b01, 2'b01, 5'd3, 5'd4)));
  endtask

  task automatic t_nostart();
    logic [31:0] v;
    clr_cnt();
    wr(0, cmdw(1'b0, 2'b00, 2'b11, 5'd7, 5'd9));
    repeat (DIV * 6) @(negedge clk);
    rd(0, v);
    check("R9 fields stored, idle", 64'(v), 64'(cmdw(1'b0, 2'b00, 2'b11, 5'd7, 5'd9)));
    check("R9 no mdc edges", 64'(bitcnt), 64'd0);
  endtask

  task automatic t_fail_clear();
    logic [31:0] v;
    phy_rd = 1'b0;
    wr(0, cmdw(1'b1, 2'b01, 2'b01, 5'd5, 5'd6));
    rd(16, v);
    check("R6 status cleared at launch", 64'(v), 64'd0);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write(2'b01, 2'b01, 5'h15, 5'h0A, 16'hA5C3, "R3 c22 write frame");
    t_write(2'b01, 2'b01, 5'h00, 5'h1F, 16'h0001, "R3 c22 write edge values");
    t_write(2'b00, 2'b00, 5'h11, 5'h03, 16'hBEEF, "R4 c45 address frame");
    t_write(2'b00, 2'b01, 5'h02, 5'h07, 16'h1234, "R4 c45 write frame");
    t_read(2'b01, 2'b10, 5'h01, 5'h02, 1'b1, 16'h9C41, "R5 c22 read");
    t_read(2'b00, 2'b11, 5'h1E, 5'h01, 1'b1, 16'h7F80, "R5 c45 read");
    t_read(2'b00, 2'b10, 5'h04, 5'h05, 1'b1, 16'h0F0F, "R10 c45 post-inc read");
    t_read(2'b01, 2'b10, 5'h09, 5'h00, 1'b0, 16'h0000, "R6 silent device read");
    t_fail_clear();
    t_period();
    t_busy_ignore();
    t_nostart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule